// File: doc/BRIEF.md
# Mode-Switched General-Purpose Port with Expansion Address Assignment

This block is an eight-bit port. Six of its pins can be inputs or outputs, and two can only be inputs. A small register bus gives access to four registers: a data latch, a direction register, an assignment register and a pull-up register. Reading the data address always returns the live pin levels. The other addresses return the stored settings.

Each of the six bidirectional pins has its own assignment bit. When that bit is set and the mode input reports expanded operation, the pin stops acting as general-purpose I/O. It then drives a high-order memory expansion address bit supplied by the bus controller. In every other case the pin follows its direction bit and drives the value held in the data latch. Pull-up requests exist only on the six bidirectional pins, and they are withheld from any pin that is currently driving.

Top module: `gpio_xport`

## Requirements
- R1: After reset, every register holds 0. As a result, `pin_oe` and `pin_pu` are all 0 and the direction, assignment and pull-up registers read back as 0.
- R2: A read with `bus_addr` = 0 (data) returns all eight bits of `pin_in`, whatever the direction, assignment and mode settings are.
- R3: A write to address 0 stores bits 5:0 in the data latch. A pin that is not in expansion drives `pin_out[i]` from latch bit i, and its `pin_oe[i]` equals direction bit i (address 1, 1 = output).
- R4: When `mode_expanded` is 1 and assignment bit i (address 2) is 1, `pin_oe[i]` is 1 and `pin_out[i]` equals `xaddr[i]`, whatever the direction bit and latch bit are. `xaddr[0]` carries expansion address bit 13 and `xaddr[5]` carries bit 18.
- R5: When `mode_expanded` is 0, the assignment bits have no effect, and every pin behaves as R3 describes.
- R6: `pin_pu[i]` equals pull-up bit i (address 3) when `pin_oe[i]` is 0. It is 0 whenever `pin_oe[i]` is 1.
- R7: Bits 7:6 of the direction, assignment and pull-up registers always read back as 0. Writes to those bits change no output.
- R8: A data write made while a pin is in expansion is kept in the latch. That value appears on `pin_out` once the pin returns to GPIO output.
- R9: A write to address 1, 2 or 3 is visible at the ports from the next clock edge on, and bits 5:0 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Access is a write when 1 |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 assignment, 3 pull-up |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| mode_expanded | input | 1 | 1 selects expanded operation |
| xaddr | input | 6 | Expansion address bits 18..13, where bit 0 is address bit 13 |
| pin_in | input | 8 | Sensed level of each pin |
| pin_out | output | 6 | Output value for pins 5..0 |
| pin_oe | output | 6 | Output enable for pins 5..0 |
| pin_pu | output | 6 | Pull-up request for pins 5..0 |

## Verification
The case hardest to reach from the ports is a data write that lands while a pin is given over to expansion. The latch cannot be read directly, and `pin_out` shows the expansion bit during that time. The bench enters expanded mode with every pin assigned and writes a distinctive latch pattern. It checks that `pin_out` still follows `xaddr`. It then clears the assignment and sets every pin to output, so the hidden latch value comes out on the pins. Writes to the reserved upper bits are checked the same way: through readback and through the pull-up and enable outputs, before any other write.

// File: rtl/xport_pkg.sv
package xport_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_ASG  = 2'd2,
    REG_PULL = 2'd3
  } xport_reg_e;

  // Value presented on one I/O pin: expansion bit or latched data.
  function automatic logic pin_value(input logic use_exp, input logic exp_bit,
                                     input logic lat_bit);
    return use_exp ? exp_bit : lat_bit;
  endfunction

  // Output enable: expansion forces drive, else direction decides.
  function automatic logic pin_drive(input logic use_exp, input logic dir_bit);
    return use_exp | dir_bit;
  endfunction

  // Pull-up request is withheld while the pin drives.
  function automatic logic pin_pull(input logic pu_bit, input logic driving);
    return pu_bit & ~driving;
  endfunction

endpackage

// File: rtl/xport_regs.sv
module xport_regs
  import xport_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int IO_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [IO_W-1:0]   lat_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] asg_q,
  output logic [PORT_W-1:0] pu_q
);

  localparam int IN_ONLY_W = PORT_W - IO_W;
  localparam logic [PORT_W-1:0] IO_MASK = {{IN_ONLY_W{1'b0}}, {IO_W{1'b1}}};

  logic wr_any, wr_data, wr_dir, wr_asg, wr_pull;
  logic [PORT_W-1:0] wdata_io;

  assign wr_any   = bus_sel & bus_wr;
  assign wr_data  = wr_any & (bus_addr == REG_DATA);
  assign wr_dir   = wr_any & (bus_addr == REG_DIR);
  assign wr_asg   = wr_any & (bus_addr == REG_ASG);
  assign wr_pull  = wr_any & (bus_addr == REG_PULL);
  assign wdata_io = bus_wdata & IO_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
      asg_q <= '0;
      pu_q  <= '0;
    end else begin
      if (wr_data) lat_q <= bus_wdata[IO_W-1:0];
      if (wr_dir)  dir_q <= wdata_io;
      if (wr_asg)  asg_q <= wdata_io;
      if (wr_pull) pu_q  <= wdata_io;
    end
  end

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q[IO_W-1:0] == $past(bus_wdata[IO_W-1:0])); // R9

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(lat_q)); // R8

  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir || wr_asg || wr_pull) |=>
      (dir_q[PORT_W-1:IO_W] | asg_q[PORT_W-1:IO_W] | pu_q[PORT_W-1:IO_W]) == '0); // R7

endmodule

// File: rtl/xport_pinmux.sv
module xport_pinmux
  import xport_pkg::*;
#(
  parameter int IO_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_expanded,
  input  logic [IO_W-1:0] xaddr,
  input  logic [IO_W-1:0] lat_q,
  input  logic [IO_W-1:0] dir_q,
  input  logic [IO_W-1:0] asg_q,
  input  logic [IO_W-1:0] pu_q,
  output logic [IO_W-1:0] pin_out,
  output logic [IO_W-1:0] pin_oe,
  output logic [IO_W-1:0] pin_pu,
  output logic [IO_W-1:0] exp_sel
);

  for (genvar i = 0; i < IO_W; i++) begin : g_pin
    assign exp_sel[i] = mode_expanded & asg_q[i];
    assign pin_out[i] = pin_value(exp_sel[i], xaddr[i], lat_q[i]);
    assign pin_oe[i]  = pin_drive(exp_sel[i], dir_q[i]);
    assign pin_pu[i]  = pin_pull(pu_q[i], pin_oe[i]);
  end

  AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0); // R6

  AST_EXP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ((exp_sel & ~pin_oe) == '0) && (((pin_out ^ xaddr) & exp_sel) == '0)); // R4

endmodule

// File: rtl/xport_readmux.sv
module xport_readmux
  import xport_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic [PORT_W-1:0] pin_in,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] asg_q,
  input  logic [PORT_W-1:0] pu_q,
  output logic [PORT_W-1:0] bus_rdata
);

  always_comb begin
    unique case (xport_reg_e'(bus_addr))
      REG_DATA: bus_rdata = pin_in;
      REG_DIR:  bus_rdata = dir_q;
      REG_ASG:  bus_rdata = asg_q;
      REG_PULL: bus_rdata = pu_q;
      default:  bus_rdata = '0;
    endcase
  end

  AST_DATA_IS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_DATA) |-> bus_rdata == pin_in); // R2

endmodule

// File: rtl/gpio_xport.sv
module gpio_xport
  import xport_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int IO_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic              mode_expanded,
  input  logic [IO_W-1:0]   xaddr,
  input  logic [PORT_W-1:0] pin_in,
  output logic [IO_W-1:0]   pin_out,
  output logic [IO_W-1:0]   pin_oe,
  output logic [IO_W-1:0]   pin_pu
);

  logic [IO_W-1:0]   lat_q;
  logic [PORT_W-1:0] dir_q, asg_q, pu_q;
  logic [IO_W-1:0]   exp_sel;

  xport_regs #(.PORT_W(PORT_W), .IO_W(IO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .lat_q(lat_q), .dir_q(dir_q), .asg_q(asg_q), .pu_q(pu_q)
  );

  xport_pinmux #(.IO_W(IO_W)) u_pinmux (
    .clk(clk), .rst_n(rst_n), .mode_expanded(mode_expanded), .xaddr(xaddr),
    .lat_q(lat_q), .dir_q(dir_q[IO_W-1:0]), .asg_q(asg_q[IO_W-1:0]),
    .pu_q(pu_q[IO_W-1:0]), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pu(pin_pu), .exp_sel(exp_sel)
  );

  xport_readmux #(.PORT_W(PORT_W)) u_readmux (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .pin_in(pin_in),
    .dir_q(dir_q), .asg_q(asg_q), .pu_q(pu_q), .bus_rdata(bus_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0) && (pin_pu == '0)); // R1

  AST_SINGLE_NO_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_expanded |-> exp_sel == '0); // R5

endmodule

// File: tb/test_gpio_xport.sv
module test_gpio_xport;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic       mode_expanded = 1'b0;
  logic [5:0] xaddr = 6'h00;
  logic [7:0] pin_in = 8'h00;
  logic [5:0] pin_out, pin_oe, pin_pu;

  int n_checks = 0;
  int n_errors = 0;

  // Shadow of the settings, kept from the requirements.
  logic [5:0] m_lat = '0, m_dir = '0, m_asg = '0, m_pu = '0;

  always #5 clk = ~clk;

  gpio_xport i_gpio_xport (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode_expanded(mode_expanded), .xaddr(xaddr), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    case (a)
      2'd0: m_lat = d[5:0];
      2'd1: m_dir = d[5:0];
      2'd2: m_asg = d[5:0];
      default: m_pu = d[5:0];
    endcase
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Expected pin outputs: expansion pins follow xaddr and drive.
  task automatic chk_pins(input string req);
    logic [5:0] take, e_oe, e_out, e_pu;
    #1;
    take  = mode_expanded ? m_asg : 6'h00;
    e_oe  = take | m_dir;
    e_out = (xaddr & take) | (m_lat & ~take);
    e_pu  = m_pu & ~e_oe;
    chk({req, " pin_oe"},  {2'b00, pin_oe},  {2'b00, e_oe});
    chk({req, " pin_out"}, {2'b00, pin_out}, {2'b00, e_out});
    chk({req, " pin_pu"},  {2'b00, pin_pu},  {2'b00, e_pu});
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 oe", {2'b00, pin_oe}, 8'h00);
    chk("R1 pu", {2'b00, pin_pu}, 8'h00);
    rd(2'd1, d); chk("R1 dir", d, 8'h00);
    rd(2'd2, d); chk("R1 asg", d, 8'h00);
    rd(2'd3, d); chk("R1 pull", d, 8'h00);
  endtask

  task automatic t_read_pins;
    logic [7:0] d;
    pin_in = 8'hA5; rd(2'd0, d); chk("R2 pins A5", d, 8'hA5);
    wr(2'd1, 8'h3F); wr(2'd2, 8'h2A); mode_expanded = 1'b1;
    pin_in = 8'h3C; rd(2'd0, d); chk("R2 pins 3C out+exp", d, 8'h3C);
    pin_in = 8'hC0; rd(2'd0, d); chk("R2 pins C0", d, 8'hC0);
    mode_expanded = 1'b0; wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_gpio_out;
    wr(2'd0, 8'h2A); wr(2'd1, 8'h0F);
    chk_pins("R3 gpio dir0F");
    wr(2'd0, 8'h15); wr(2'd1, 8'h30);
    chk_pins("R3 gpio dir30");
  endtask

  task automatic t_expand;
    wr(2'd0, 8'h2A); wr(2'd1, 8'h00); wr(2'd2, 8'h31);
    mode_expanded = 1'b1; xaddr = 6'h15;
    chk_pins("R4 exp asg31");
    chk("R4 out value", {2'b00, pin_out}, 8'h1B);
    chk("R4 oe value", {2'b00, pin_oe}, 8'h31);
    xaddr = 6'h2E; wr(2'd1, 8'h3F);
    chk_pins("R4 exp dir ignored");
  endtask

  task automatic t_single;
    mode_expanded = 1'b0; xaddr = 6'h3F;
    chk_pins("R5 single asg ignored");
    chk("R5 oe is dir", {2'b00, pin_oe}, 8'h3F);
    chk("R5 out is latch", {2'b00, pin_out}, 8'h2A);
  endtask

  task automatic t_pull;
    wr(2'd2, 8'h00); wr(2'd1, 8'h0F); wr(2'd3, 8'h3F);
    chk_pins("R6 pull gpio");
    chk("R6 pu value", {2'b00, pin_pu}, 8'h30);
    wr(2'd1, 8'h00); wr(2'd2, 8'h30); mode_expanded = 1'b1;
    chk_pins("R6 pull exp");
    chk("R6 pu exp value", {2'b00, pin_pu}, 8'h0F);
    mode_expanded = 1'b0; wr(2'd2, 8'h00);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    wr(2'd3, 8'hC0);
    chk("R7 pu after C0", {2'b00, pin_pu}, 8'h00);
    rd(2'd3, d); chk("R7 pull rb", d, 8'h00);
    wr(2'd1, 8'hC0);
    chk("R7 oe after C0", {2'b00, pin_oe}, 8'h00);
    rd(2'd1, d); chk("R7 dir rb", d, 8'h00);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R7 asg rb", d, 8'h3F);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_latch_exp;
    mode_expanded = 1'b1; xaddr = 6'h00;
    wr(2'd1, 8'h00); wr(2'd2, 8'h3F); wr(2'd0, 8'h15);
    chk("R8 hidden while exp", {2'b00, pin_out}, 8'h00);
    wr(2'd2, 8'h00); wr(2'd1, 8'h3F);
    chk_pins("R8 back to gpio");
    chk("R8 latch value", {2'b00, pin_out}, 8'h15);
    mode_expanded = 1'b0;
  endtask

  task automatic t_readback;
    logic [7:0] d;
    wr(2'd1, 8'h2D); rd(2'd1, d); chk("R9 dir rb", d, 8'h2D);
    wr(2'd2, 8'h12); rd(2'd2, d); chk("R9 asg rb", d, 8'h12);
    wr(2'd3, 8'h21); rd(2'd3, d); chk("R9 pull rb", d, 8'h21);
    chk_pins("R9 outputs follow");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    #1 t_reset();
    t_read_pins();
    t_gpio_out();
    t_expand();
    t_single();
    t_pull();
    t_reserved();
    t_latch_exp();
    t_readback();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule